// File: doc/BRIEF.md
# Translation-Miss Page Table Walker

This block resolves a virtual address that missed in the translation cache. It takes a request holding a 32-bit virtual address and an access kind (read, write or execute). From the current table base it forms the address of the single page table entry that covers the page and fetches that entry over a plain memory request/response port. It then checks the entry's valid and permission bits and returns either a physical address or a fault code. Pages are 4 KB, so the low 12 bits of the virtual address are copied through to the physical address unchanged. Each entry is 4 bytes wide.

When an access succeeds, the walker marks the entry as referenced, and on a write also as dirty. If either bit really changes, it writes the updated entry back to the same address before it replies. The table base is a single register. On a context switch it is loaded through a write port that only takes effect in privileged mode. One walk runs at a time.

Entry layout: bit 0 valid, bit 1 read allowed, bit 2 write allowed, bit 3 execute allowed, bit 4 referenced, bit 5 dirty, bits 11:6 kept unchanged, bits 31:12 physical page number.

Top module: `pte_walker`

## Requirements
- R1: The read request for a walk carries the address base + (vaddr[31:12] * 4), modulo 2^32. The base used is the one held when the walk was accepted.
- R2: A walk with no fault replies with done_paddr = {entry[31:12], vaddr[11:0]} and done_fault = 0.
- R3: If the fetched entry has bit 0 clear, the reply carries done_fault = 1 (not present) and done_paddr = 0, and no write request is issued. This check takes priority over the permission check.
- R4: If the entry is valid but lacks the permission the access needs, the reply carries done_fault = 2 (protection), done_paddr = 0, and no write request is issued. The kind codes are 0 read (needs bit 1), 1 write (needs bit 2) and 2 execute (needs bit 3). Kind 3 always faults.
- R5: A successful access writes back the entry with bit 4 set, to the same address, before the reply.
- R6: A successful write access also sets bit 5 in the written-back entry. All other entry bits are written back unchanged.
- R7: When the reference bit (and, for a write, the dirty bit) is already set, no write request is issued, and the reply comes in the cycle after the read response.
- R8: busy is high from the cycle after a request is accepted through the reply cycle. req_ready is its inverse. A request presented while busy is ignored. done_valid is a one-cycle pulse.
- R9: The base register loads base_wdata only when base_we and base_priv are both high. An unprivileged write has no effect on later walks.
- R10: A memory request holds its valid, write flag, address and data steady until mem_req_ready is seen.
- R11: After reset the walker is idle: busy low, req_ready high, no memory request and no reply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_we | input | 1 | Table base write strobe |
| base_priv | input | 1 | Writer is in privileged mode |
| base_wdata | input | 32 | New table base |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_kind | input | 2 | Access kind: 0 read, 1 write, 2 execute |
| req_ready | output | 1 | Walker can accept a request |
| busy | output | 1 | Walk in progress |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_write | output | 1 | Memory request is a write-back |
| mem_req_addr | output | 32 | Entry address |
| mem_req_wdata | output | 32 | Updated entry for write-back |
| mem_req_ready | input | 1 | Memory accepts the request |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Fetched entry |
| done_valid | output | 1 | Reply pulse |
| done_paddr | output | 32 | Translated physical address |
| done_fault | output | 2 | 0 none, 1 not present, 2 protection |

## Verification
A wrong table base or a bad latched page number shows on mem_req_addr in the first cycle after a request is accepted. A mistake in the entry update shows on mem_req_wdata in the cycle after the read response. A faulty sequencer state shows within one cycle, because busy is compared with the bench's own expectation on every clock. A wrong fault decision appears either as an unexpected write request or as a mismatch in the reply fields. Both are visible at most two cycles after the response.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    typedef enum logic [1:0] {
        ACC_READ  = 2'd0,
        ACC_WRITE = 2'd1,
        ACC_EXEC  = 2'd2,
        ACC_RSVD  = 2'd3
    } access_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_PROT   = 2'd2
    } fault_e;

    typedef enum logic [2:0] {
        WS_IDLE,
        WS_FETCH,
        WS_AWAIT,
        WS_STORE,
        WS_REPLY
    } walk_state_e;

    localparam int unsigned BIT_VALID = 0;
    localparam int unsigned BIT_RD    = 1;
    localparam int unsigned BIT_WR    = 2;
    localparam int unsigned BIT_EX    = 3;
    localparam int unsigned BIT_REF   = 4;
    localparam int unsigned BIT_DIRTY = 5;
endpackage

// File: rtl/pgw_addr.sv
module pgw_addr #(
    parameter int unsigned ADDR_W    = 32,
    parameter int unsigned VPN_W     = 20,
    parameter int unsigned PTE_BYTES = 4
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [VPN_W-1:0]  vpn,
    output logic [ADDR_W-1:0] pte_addr
);
    localparam int unsigned SCALE_SH = $clog2(PTE_BYTES);

    logic [ADDR_W-1:0] vpn_ext;
    logic [ADDR_W-1:0] index_bytes;

    always_comb begin
        vpn_ext     = {{(ADDR_W-VPN_W){1'b0}}, vpn};
        index_bytes = vpn_ext << SCALE_SH;
        pte_addr    = base + index_bytes;
    end
endmodule

// File: rtl/pgw_perm.sv
module pgw_perm
    import pgw_pkg::*;
#(
    parameter int unsigned PTE_W = 32,
    parameter int unsigned OFF_W = 12
) (
    input  logic [PTE_W-1:0]       pte,
    input  access_e                kind,
    output fault_e                 fault,
    output logic [PTE_W-1:0]       pte_upd,
    output logic                   wb_needed,
    output logic [PTE_W-OFF_W-1:0] ppn
);
    logic allowed;
    logic [PTE_W-1:0] mark;

    always_comb begin
        unique case (kind)
            ACC_READ:  allowed = pte[BIT_RD];
            ACC_WRITE: allowed = pte[BIT_WR];
            ACC_EXEC:  allowed = pte[BIT_EX];
            default:   allowed = 1'b0;
        endcase

        if (!pte[BIT_VALID])  fault = FLT_ABSENT;
        else if (!allowed)    fault = FLT_PROT;
        else                  fault = FLT_NONE;

        mark = '0;
        mark[BIT_REF] = 1'b1;
        if (kind == ACC_WRITE) mark[BIT_DIRTY] = 1'b1;

        pte_upd   = pte | mark;
        wb_needed = (fault == FLT_NONE) && (pte_upd != pte);
        ppn       = pte[PTE_W-1:OFF_W];
    end
endmodule

// File: rtl/pgw_seq.sv
module pgw_seq
    import pgw_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        mem_req_ready,
    input  logic        mem_rsp_valid,
    input  logic        wb_needed,
    output walk_state_e state
);
    walk_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WS_IDLE:  if (req_valid)     state_d = WS_FETCH;
            WS_FETCH: if (mem_req_ready) state_d = WS_AWAIT;
            WS_AWAIT: if (mem_rsp_valid) state_d = wb_needed ? WS_STORE : WS_REPLY;
            WS_STORE: if (mem_req_ready) state_d = WS_REPLY;
            WS_REPLY:                    state_d = WS_IDLE;
            default:                     state_d = WS_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= WS_IDLE;
        else        state_q <= state_d;
    end

    assign state = state_q;
endmodule

// File: rtl/pte_walker.sv
module pte_walker
    import pgw_pkg::*;
#(
    parameter int unsigned VA_W      = 32,
    parameter int unsigned PTE_W     = 32,
    parameter int unsigned OFF_W     = 12,
    parameter int unsigned PTE_BYTES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             base_we,
    input  logic             base_priv,
    input  logic [PTE_W-1:0] base_wdata,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_vaddr,
    input  logic [1:0]       req_kind,
    output logic             req_ready,
    output logic             busy,
    output logic             mem_req_valid,
    output logic             mem_req_write,
    output logic [PTE_W-1:0] mem_req_addr,
    output logic [PTE_W-1:0] mem_req_wdata,
    input  logic             mem_req_ready,
    input  logic             mem_rsp_valid,
    input  logic [PTE_W-1:0] mem_rsp_data,
    output logic             done_valid,
    output logic [PTE_W-1:0] done_paddr,
    output logic [1:0]       done_fault
);
    localparam int unsigned VPN_W = VA_W - OFF_W;
    localparam int unsigned PPN_W = PTE_W - OFF_W;

    typedef struct packed {
        logic [PTE_W-1:0] base;
        logic [PTE_W-1:0] pte_addr;
        logic [OFF_W-1:0] offset;
        access_e          kind;
        logic [PTE_W-1:0] wb_data;
        logic [PPN_W-1:0] ppn;
        fault_e           fault;
    } walk_regs_t;

    walk_regs_t  r_d, r_q;
    walk_state_e state;
    logic [PTE_W-1:0] addr_calc;
    fault_e           chk_fault;
    logic [PTE_W-1:0] chk_upd;
    logic             chk_wb;
    logic [PPN_W-1:0] chk_ppn;
    logic             accept;
    logic             rsp_take;

    pgw_addr #(.ADDR_W(PTE_W), .VPN_W(VPN_W), .PTE_BYTES(PTE_BYTES)) u_addr (
        .base     (r_q.base),
        .vpn      (req_vaddr[VA_W-1:OFF_W]),
        .pte_addr (addr_calc)
    );

    pgw_perm #(.PTE_W(PTE_W), .OFF_W(OFF_W)) u_perm (
        .pte       (mem_rsp_data),
        .kind      (r_q.kind),
        .fault     (chk_fault),
        .pte_upd   (chk_upd),
        .wb_needed (chk_wb),
        .ppn       (chk_ppn)
    );

    pgw_seq u_seq (
        .clk           (clk),
        .rst_n         (rst_n),
        .req_valid     (req_valid),
        .mem_req_ready (mem_req_ready),
        .mem_rsp_valid (mem_rsp_valid),
        .wb_needed     (chk_wb),
        .state         (state)
    );

    always_comb begin
        accept   = (state == WS_IDLE) && req_valid;
        rsp_take = (state == WS_AWAIT) && mem_rsp_valid;
        r_d      = r_q;
        if (base_we && base_priv) r_d.base = base_wdata;
        if (accept) begin
            r_d.pte_addr = addr_calc;
            r_d.offset   = req_vaddr[OFF_W-1:0];
            r_d.kind     = access_e'(req_kind);
        end
        if (rsp_take) begin
            r_d.wb_data = chk_upd;
            r_d.ppn     = chk_ppn;
            r_d.fault   = chk_fault;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{base: '0, pte_addr: '0, offset: '0, kind: ACC_READ,
                     wb_data: '0, ppn: '0, fault: FLT_NONE};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        busy          = (state != WS_IDLE);
        req_ready     = !busy;
        mem_req_valid = (state == WS_FETCH) || (state == WS_STORE);
        mem_req_write = (state == WS_STORE);
        mem_req_addr  = r_q.pte_addr;
        mem_req_wdata = r_q.wb_data;
        done_valid    = (state == WS_REPLY);
        done_fault    = r_q.fault;
        done_paddr    = (r_q.fault == FLT_NONE) ? {r_q.ppn, r_q.offset} : '0;
    end

    assert_req_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_write) && $stable(mem_req_addr) && $stable(mem_req_wdata)));

    assert_reply_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_reply_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> busy);

    assert_wb_valid_entry_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> (mem_req_wdata[BIT_VALID] && done_fault == 2'd0));

    assert_wb_ref_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write) |-> mem_req_wdata[BIT_REF]);

    assert_fault_zero_pa_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && done_fault != 2'd0) |-> (done_paddr == '0));
endmodule

// File: tb/pte_walker_test.sv
module pte_walker_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        base_we = 1'b0, base_priv = 1'b0;
    logic [31:0] base_wdata = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_kind = '0;
    logic        req_ready, busy, mem_req_valid, mem_req_write;
    logic [31:0] mem_req_addr, mem_req_wdata;
    logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        done_valid;
    logic [31:0] done_paddr;
    logic [1:0]  done_fault;

    int n_chk = 0, n_fail = 0;
    bit exp_busy = 1'b0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pte_walker uut (
        .clk(clk), .rst_n(rst_n), .base_we(base_we), .base_priv(base_priv),
        .base_wdata(base_wdata), .req_valid(req_valid), .req_vaddr(req_vaddr),
        .req_kind(req_kind), .req_ready(req_ready), .busy(busy),
        .mem_req_valid(mem_req_valid), .mem_req_write(mem_req_write),
        .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
        .mem_req_ready(mem_req_ready), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_data(mem_rsp_data), .done_valid(done_valid),
        .done_paddr(done_paddr), .done_fault(done_fault)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // per-clock comparison of the busy level with the bench's own tracking
    always @(posedge clk) begin
        #3;
        if (rst_n && !finished) begin
            chk("R8 busy level", {31'd0, busy}, {31'd0, exp_busy});
            chk("R8 ready inverse", {31'd0, req_ready}, {31'd0, !exp_busy});
        end
    end

    task automatic load_base(input logic [31:0] v, input bit priv);
        @(negedge clk);
        base_we = 1'b1; base_priv = priv; base_wdata = v;
        @(negedge clk);
        base_we = 1'b0; base_priv = 1'b0;
    endtask

    task automatic walk(input logic [31:0] va, input logic [1:0] kind, input logic [31:0] pte,
                        input logic [31:0] base, input int hold, input int lat, input bit poke);
        logic [31:0] e_addr, e_wb, e_pa;
        logic [1:0]  e_flt;
        bit          ok, e_store;
        e_addr = base + {va[31:12], 2'b00};
        case (kind)
            2'd0: ok = pte[1];
            2'd1: ok = pte[2];
            2'd2: ok = pte[3];
            default: ok = 1'b0;
        endcase
        e_flt   = !pte[0] ? 2'd1 : (!ok ? 2'd2 : 2'd0);
        e_wb    = pte | 32'h10 | ((kind == 2'd1) ? 32'h20 : 32'h0);
        e_store = (e_flt == 2'd0) && (e_wb != pte);
        e_pa    = (e_flt == 2'd0) ? {pte[31:12], va[11:0]} : 32'h0;

        @(negedge clk);
        chk("R8 ready before request", {31'd0, req_ready}, 32'd1);
        req_valid = 1'b1; req_vaddr = va; req_kind = kind;
        exp_busy = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R1 read request valid", {31'd0, mem_req_valid}, 32'd1);
        chk("R1 read request is read", {31'd0, mem_req_write}, 32'd0);
        chk("R1 entry address", mem_req_addr, e_addr);
        for (int i = 0; i < hold; i++) begin
            @(negedge clk);
            chk("R10 read held", {31'd0, mem_req_valid}, 32'd1);
            chk("R10 address held", mem_req_addr, e_addr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        if (poke) begin
            req_valid = 1'b1; req_vaddr = va ^ 32'hFFFF_F0F0; req_kind = 2'd0;
        end
        for (int i = 0; i < lat; i++) begin
            @(negedge clk);
            chk("R10 no request while waiting", {31'd0, mem_req_valid}, 32'd0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_data = pte;
        @(negedge clk);
        mem_rsp_valid = 1'b0; mem_rsp_data = 32'hDEAD_BEEF;
        if (e_store) begin
            chk("R5 write-back issued", {31'd0, mem_req_valid & mem_req_write}, 32'd1);
            chk("R5 write-back address", mem_req_addr, e_addr);
            chk("R6 write-back data", mem_req_wdata, e_wb);
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
        end else begin
            chk("R7 no write-back", {31'd0, mem_req_valid}, 32'd0);
        end
        chk("R8 reply pulse", {31'd0, done_valid}, 32'd1);
        chk("R3 R4 fault code", {30'd0, done_fault}, {30'd0, e_flt});
        chk("R2 physical address", done_paddr, e_pa);
        req_valid = 1'b0;
        exp_busy = 1'b0;
        @(negedge clk);
        chk("R8 reply ends", {31'd0, done_valid}, 32'd0);
        chk("R8 poke ignored", {31'd0, mem_req_valid}, 32'd0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 reset busy", {31'd0, busy}, 32'd0);
        chk("R11 reset ready", {31'd0, req_ready}, 32'd1);
        chk("R11 reset mem request", {31'd0, mem_req_valid}, 32'd0);
        chk("R11 reset reply", {31'd0, done_valid}, 32'd0);
        rst_n = 1'b1;
        load_base(32'h0040_0000, 1'b1);
        // R5: read sets reference bit
        walk(32'h1234_5ABC, 2'd0, 32'hABCDE_003, 32'h0040_0000, 0, 0, 0);
        // R6: write sets dirty (ref already set)
        walk(32'h0000_1FFF, 2'd1, 32'h11111_017, 32'h0040_0000, 0, 1, 0);
        // R7: read, ref already set
        walk(32'h0002_3004, 2'd0, 32'h22222_013, 32'h0040_0000, 0, 0, 0);
        // R7: write, ref and dirty already set, spare bits kept
        walk(32'h0003_4008, 2'd1, 32'h33333_FF7, 32'h0040_0000, 0, 0, 0);
        // R6: write from clean unreferenced entry, spare bits kept
        walk(32'h0004_5010, 2'd1, 32'h44444_AC7, 32'h0040_0000, 0, 0, 0);
        // R4: execute without execute permission
        walk(32'h0005_6000, 2'd2, 32'h55555_007, 32'h0040_0000, 0, 0, 0);
        // R4: write without write permission
        walk(32'h0006_7000, 2'd1, 32'h66666_00B, 32'h0040_0000, 0, 0, 0);
        // R4: reserved kind
        walk(32'h0007_8000, 2'd3, 32'h77777_00F, 32'h0040_0000, 0, 0, 0);
        // R3: not present takes priority
        walk(32'h0008_9000, 2'd2, 32'h88888_03E, 32'h0040_0000, 0, 0, 0);
        // R2: execute allowed
        walk(32'h0009_A123, 2'd2, 32'h99999_009, 32'h0040_0000, 0, 0, 0);
        // R10 R8: stalled memory and request while busy
        walk(32'h000A_B456, 2'd0, 32'hAAAAA_003, 32'h0040_0000, 3, 2, 1);
        // R9: unprivileged write ignored
        load_base(32'h7770_0000, 1'b0);
        walk(32'h000C_D000, 2'd0, 32'hBBBBB_013, 32'h0040_0000, 0, 0, 0);
        // R9: privileged write takes effect; R1 wraparound at top
        load_base(32'hFFF0_0000, 1'b1);
        walk(32'hFFFF_FFFF, 2'd1, 32'hCCCCC_007, 32'hFFF0_0000, 1, 0, 0);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule